// File: doc/BRIEF.md
# Two-Bank Programmable Logic Fabric

This block is a small programmable logic fabric of sixteen cells split into two banks of eight. Each cell forms two operands: one from its own input pin or from a feedback route, and one from a software data bit or from another feedback route. The cell feeds the two operands into a four-entry truth table. It can then pass the table result straight out or take it from its flip-flop. A cell's feedback can come from cells of its own bank, and the first cell of each bank is the only one that can reach the last cell of the other bank. Each bank's flip-flops advance only when that bank's selected clock-enable source is high.

Software sets up the fabric through a small synchronous register bus. The register set holds one configuration word per cell, a clock-select word, an interrupt-routing word, a conversion-start routing word, a software data word that drives one bit into each cell, and a read-only word that captures all cell outputs on every clock. The sixteen cell outputs drive sixteen output pins. Any cell can be routed to either of two level interrupt lines or to the conversion-start line.

Top module: `pla_array`

## Requirements
- R1: A write (reg_we high) to word addresses 0..19 updates the register on the next clock edge. reg_rdata is combinational from reg_addr. Cell words read back bits [10:0], the clock-select word bits [2:0] and [6:4], the interrupt word bits [3:0], 7, [11:8] and 15, the conversion-start word bits [3:0] and the software data word (address 19) bits [15:0]. All other bits, and addresses 21..31, read 0. Writes to addresses 20..31 have no effect.
- R2: The cell configuration word at address n has this layout: bits [9:6] are the truth table, and the cell's table output is bit (6 + 2*A + B) of the word, where A and B are the two operands.
- R3: Operand A is pin_in[n] when bit 5 is 1 and the first feedback route when bit 5 is 0. Operand B is the second feedback route when bit 4 is 1 and bit n of the software data word when bit 4 is 0.
- R4: The first feedback route takes code bits [1:0]. Code 0 gives cell 15 for cell 0, cell 7 for cell 8, cell 0 for cells 1..7 and cell 8 for cells 9..15. Code k (k=1..3) gives bank base + 2k. The second feedback route takes code bits [3:2], and code k gives bank base + 2k + 1. Feedback always carries the source cell's flip-flop state.
- R5: Every cell's flip-flop loads the table output on each clock edge where its bank is enabled, and holds otherwise. pin_out[n] is the flip-flop state when bit 10 is 1 and the table output when bit 10 is 0.
- R6: The clock-select word (address 16) holds bank 0's code in bits [2:0] and bank 1's code in bits [6:4]. Code 0 enables the bank on every clock, and code k (1..7) enables it when ce_src[k] is high.
- R7: Reading address 20 returns, in bits [15:0], the sixteen cell outputs as they were in the previous clock cycle.
- R8: The interrupt word (address 17) holds the source cell of irq_out[0] in bits [3:0] with its enable in bit 7, and the source cell of irq_out[1] in bits [11:8] with its enable in bit 15. Each irq_out line equals its source cell's output when enabled and 0 otherwise.
- R9: adc_start equals the output of the cell named in bits [3:0] of address 18.
- R10: With rst_n low at a clock edge, every register and flip-flop clears. All outputs and all register reads are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pin_in | input | 16 | Per-cell input pins (bit n to cell n) |
| ce_src | input | 8 | Clock-enable sources selectable per bank |
| pin_out | output | 16 | Per-cell output pins |
| irq_out | output | 2 | Level interrupt lines |
| adc_start | output | 1 | Conversion-start signal |

## Verification
The hardest case to set up from the ports is the cross-bank loop. It needs cell 15 latching a pin into its flip-flop, cell 0 picking it up through route code 0, and the same thing mirrored from cell 7 into cell 8, all while the bank enables gate which edges count. The bench writes exactly that configuration and then drives random pins and random enable sources. A behavioural model predicts every output each cycle, so a wrong source index or a missed hold shows up at once. A long random phase then writes random words to random addresses, unmapped ones included, so that routing codes, table contents and clock-select codes reach combinations that directed cases would not cover.

// File: rtl/pla_pkg.sv
// Shared constants, configuration layout and feedback index helpers for the
// two-bank logic fabric. Assumes banks of eight cells (two-bit route codes).
package pla_pkg;

    localparam int NUM_BANKS  = 2;
    localparam int BANK_SIZE  = 8;
    localparam int NUM_ELEM   = NUM_BANKS * BANK_SIZE;
    localparam int ELEM_W     = $clog2(NUM_ELEM);
    localparam int CLKSEL_W   = 3;
    localparam int NUM_CE     = 2 ** CLKSEL_W;
    localparam int NUM_IRQ    = 2;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int CLK_STRIDE = 4;   // bit spacing of bank codes in clock word
    localparam int IRQ_STRIDE = 8;   // bit spacing of interrupt fields

    localparam int ADDR_CLKSEL = NUM_ELEM;
    localparam int ADDR_IRQ    = NUM_ELEM + 1;
    localparam int ADDR_ADC    = NUM_ELEM + 2;
    localparam int ADDR_DIN    = NUM_ELEM + 3;
    localparam int ADDR_DOUT   = NUM_ELEM + 4;

    // Per-cell configuration word, bit 10 down to bit 0.
    typedef struct packed {
        logic       use_ff;    // 1: output from flip-flop
        logic [3:0] lut;       // truth table, entry 2*A+B
        logic       a_pin;     // 1: operand A from pin
        logic       b_fb;      // 1: operand B from odd route
        logic [1:0] sel_odd;   // odd feedback route code
        logic [1:0] sel_even;  // even feedback route code
    } elem_cfg_t;

    localparam int CFG_W = $bits(elem_cfg_t);

    // Source cell of the even route for a cell and code.
    function automatic int even_src(int elem, logic [1:0] code);
        int bank;
        int base;
        bank = elem / BANK_SIZE;
        base = bank * BANK_SIZE;
        if (code == 2'd0) begin
            if (elem == base)
                return ((bank + NUM_BANKS - 1) % NUM_BANKS) * BANK_SIZE + BANK_SIZE - 1;
            return base;
        end
        return base + 2 * int'(code);
    endfunction

    // Source cell of the odd route for a cell and code.
    function automatic int odd_src(int elem, logic [1:0] code);
        return (elem / BANK_SIZE) * BANK_SIZE + 2 * int'(code) + 1;
    endfunction

endpackage

// File: rtl/pla_element.sv
// One fabric cell: two operand selectors, a four-entry truth table and a
// flip-flop. Assumes feedback vector holds flip-flop states of all cells.
module pla_element
    import pla_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  elem_cfg_t           cfg,
    input  logic                pin,
    input  logic                din_bit,
    input  logic [NUM_ELEM-1:0] fb,
    output logic                out,
    output logic                q
);

    logic even_fb;
    logic odd_fb;
    logic op_a;
    logic op_b;
    logic lut_o;

    // Pick the two feedback routes from the flip-flop vector.
    always_comb begin
        even_fb = fb[ELEM_W'(even_src(IDX, cfg.sel_even))];
        odd_fb  = fb[ELEM_W'(odd_src(IDX, cfg.sel_odd))];
    end

    // Form the operands and look up the truth table.
    always_comb begin
        op_a  = cfg.a_pin ? pin : even_fb;
        op_b  = cfg.b_fb ? odd_fb : din_bit;
        lut_o = cfg.lut[{op_a, op_b}];
    end

    // Cell flip-flop, advanced only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (ce)
            q <= lut_o;
    end

    // Output choice between registered and direct table result.
    always_comb begin
        out = cfg.use_ff ? q : lut_o;
    end

    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (q == $past(lut_o)));                                   // R5
    AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));                                           // R5

endmodule

// File: rtl/pla_bank.sv
// One bank of eight cells sharing a clock-enable selection.
// Assumes ce_src bit 0 is never consulted because code 0 is always enabled.
module pla_bank
    import pla_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  elem_cfg_t [BANK_SIZE-1:0]     cfg,
    input  logic      [CLKSEL_W-1:0]      clk_sel,
    input  logic      [NUM_CE-1:0]        ce_src,
    input  logic      [BANK_SIZE-1:0]     pin,
    input  logic      [BANK_SIZE-1:0]     din,
    input  logic      [NUM_ELEM-1:0]      fb,
    output logic      [BANK_SIZE-1:0]     out,
    output logic      [BANK_SIZE-1:0]     q
);

    logic bank_ce;

    // Bank enable: code 0 runs on every edge, others follow a source.
    always_comb begin
        bank_ce = (clk_sel == '0) | ce_src[clk_sel];
    end

    for (genvar e = 0; e < BANK_SIZE; e++) begin : g_elem
        pla_element #(
            .IDX (BANK * BANK_SIZE + e)
        ) u_elem (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (bank_ce),
            .cfg     (cfg[e]),
            .pin     (pin[e]),
            .din_bit (din[e]),
            .fb      (fb),
            .out     (out[e]),
            .q       (q[e])
        );
    end

endmodule

// File: rtl/pla_regs.sv
// Register file of the fabric: cell words, clock select, interrupt and
// conversion-start routing, software data and captured outputs.
// Assumes a single-cycle synchronous bus with combinational read data.
module pla_regs
    import pla_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic                                   reg_we,
    input  logic [DATA_W-1:0]                      reg_wdata,
    output logic [DATA_W-1:0]                      reg_rdata,
    input  logic [NUM_ELEM-1:0]                    elem_out,
    output elem_cfg_t [NUM_ELEM-1:0]               cfg,
    output logic [NUM_BANKS-1:0][CLKSEL_W-1:0]     clk_sel,
    output logic [NUM_IRQ-1:0][ELEM_W-1:0]         irq_src,
    output logic [NUM_IRQ-1:0]                     irq_en,
    output logic [ELEM_W-1:0]                      adc_src,
    output logic [NUM_ELEM-1:0]                    din
);

    logic [NUM_ELEM-1:0] dout_q;
    logic                hit_cfg;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_ELEM];

    // Decode whether the address names a cell configuration word.
    always_comb begin
        hit_cfg = (reg_addr < ADDR_W'(NUM_ELEM));
    end

    // Bus writes into the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            clk_sel <= '0;
            irq_src <= '0;
            irq_en  <= '0;
            adc_src <= '0;
            din     <= '0;
        end else if (reg_we) begin
            if (hit_cfg)
                cfg[reg_addr[ELEM_W-1:0]] <= reg_wdata[CFG_W-1:0];
            if (reg_addr == ADDR_W'(ADDR_CLKSEL))
                for (int b = 0; b < NUM_BANKS; b++)
                    clk_sel[b] <= reg_wdata[b*CLK_STRIDE +: CLKSEL_W];
            if (reg_addr == ADDR_W'(ADDR_IRQ))
                for (int i = 0; i < NUM_IRQ; i++) begin
                    irq_src[i] <= reg_wdata[i*IRQ_STRIDE +: ELEM_W];
                    irq_en[i]  <= reg_wdata[i*IRQ_STRIDE + IRQ_STRIDE - 1];
                end
            if (reg_addr == ADDR_W'(ADDR_ADC))
                adc_src <= reg_wdata[ELEM_W-1:0];
            if (reg_addr == ADDR_W'(ADDR_DIN))
                din <= reg_wdata[NUM_ELEM-1:0];
        end
    end

    // Capture all cell outputs on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else
            dout_q <= elem_out;
    end

    // Combinational read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (hit_cfg)
            reg_rdata[CFG_W-1:0] = cfg[reg_addr[ELEM_W-1:0]];
        else if (reg_addr == ADDR_W'(ADDR_CLKSEL))
            for (int b = 0; b < NUM_BANKS; b++)
                reg_rdata[b*CLK_STRIDE +: CLKSEL_W] = clk_sel[b];
        else if (reg_addr == ADDR_W'(ADDR_IRQ))
            for (int i = 0; i < NUM_IRQ; i++) begin
                reg_rdata[i*IRQ_STRIDE +: ELEM_W]           = irq_src[i];
                reg_rdata[i*IRQ_STRIDE + IRQ_STRIDE - 1]    = irq_en[i];
            end
        else if (reg_addr == ADDR_W'(ADDR_ADC))
            reg_rdata[ELEM_W-1:0] = adc_src;
        else if (reg_addr == ADDR_W'(ADDR_DIN))
            reg_rdata[NUM_ELEM-1:0] = din;
        else if (reg_addr == ADDR_W'(ADDR_DOUT))
            reg_rdata[NUM_ELEM-1:0] = dout_q;
    end

    AST_DIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(ADDR_DIN))
        |=> (din == $past(reg_wdata[NUM_ELEM-1:0])));                  // R1
    AST_DOUT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (dout_q == $past(elem_out)));                        // R7

endmodule

// File: rtl/pla_array.sv
// Top of the two-bank logic fabric: register file, two banks, and routing
// of cell outputs to pins, interrupt lines and the conversion-start line.
// Assumes all inputs are synchronous to clk.
module pla_array
    import pla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_ELEM-1:0]  pin_in,
    input  logic [NUM_CE-1:0]    ce_src,
    output logic [NUM_ELEM-1:0]  pin_out,
    output logic [NUM_IRQ-1:0]   irq_out,
    output logic                 adc_start
);

    elem_cfg_t [NUM_ELEM-1:0]               cfg;
    logic [NUM_BANKS-1:0][CLKSEL_W-1:0]     clk_sel;
    logic [NUM_IRQ-1:0][ELEM_W-1:0]         irq_src;
    logic [NUM_IRQ-1:0]                     irq_en;
    logic [ELEM_W-1:0]                      adc_src;
    logic [NUM_ELEM-1:0]                    din;
    logic [NUM_ELEM-1:0]                    elem_out;
    logic [NUM_ELEM-1:0]                    elem_q;

    pla_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .elem_out  (elem_out),
        .cfg       (cfg),
        .clk_sel   (clk_sel),
        .irq_src   (irq_src),
        .irq_en    (irq_en),
        .adc_src   (adc_src),
        .din       (din)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pla_bank #(
            .BANK (b)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg[b*BANK_SIZE +: BANK_SIZE]),
            .clk_sel (clk_sel[b]),
            .ce_src  (ce_src),
            .pin     (pin_in[b*BANK_SIZE +: BANK_SIZE]),
            .din     (din[b*BANK_SIZE +: BANK_SIZE]),
            .fb      (elem_q),
            .out     (elem_out[b*BANK_SIZE +: BANK_SIZE]),
            .q       (elem_q[b*BANK_SIZE +: BANK_SIZE])
        );
    end

    // Cell outputs drive the output pins one to one.
    always_comb begin
        pin_out = elem_out;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        // Gated level interrupt from the routed cell.
        always_comb begin
            irq_out[i] = irq_en[i] & elem_out[irq_src[i]];
        end
    end

    // Conversion-start follows the routed cell.
    always_comb begin
        adc_start = elem_out[adc_src];
    end

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic [7:0]  ce_src = '0;
    logic [15:0] pin_out;
    logic [1:0]  irq_out;
    logic        adc_start;

    int n_checks = 0;
    int n_fails  = 0;

    // Behavioural reference state.
    logic [10:0] m_cfg [16];
    logic [31:0] m_clk, m_irq, m_adc, m_din;
    logic [15:0] m_dout, m_q;

    always #5 clk = ~clk;

    pla_array u_pla_array (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .ce_src(ce_src), .pin_out(pin_out), .irq_out(irq_out),
        .adc_start(adc_start)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_lut(input logic [15:0] pins);
        logic [15:0] r;
        for (int n = 0; n < 16; n++) begin
            int base, i0, i1, li;
            logic a, b;
            logic [10:0] c;
            c = m_cfg[n];
            base = (n / 8) * 8;
            if (c[1:0] == 0) i0 = (n == 0) ? 15 : (n == 8) ? 7 : base;
            else             i0 = base + 2 * c[1:0];
            i1 = base + 2 * c[3:2] + 1;
            a = c[5] ? pins[n] : m_q[i0];
            b = c[4] ? m_q[i1] : m_din[n];
            li = 2 * a + b;
            r[n] = c[6 + li];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_read(input int addr);
        if (addr < 16)  return {21'd0, m_cfg[addr]};
        if (addr == 16) return m_clk & 32'h77;
        if (addr == 17) return m_irq & 32'h8F8F;
        if (addr == 18) return m_adc & 32'hF;
        if (addr == 19) return m_din & 32'hFFFF;
        if (addr == 20) return {16'd0, m_dout};
        return 32'd0;
    endfunction

    // One bus cycle: drive at the falling edge, compare, then advance model.
    task automatic step(input logic we, input int addr, input logic [31:0] data,
                        input string rtag);
        logic [15:0] lut, outs;
        logic        ce0, ce1;
        int          c0, c1;
        logic        e_irq0, e_irq1, e_adc;
        @(negedge clk);
        reg_we    = we;
        reg_addr  = addr[4:0];
        reg_wdata = data;
        pin_in    = 16'($urandom);
        ce_src    = 8'($urandom);
        #1;
        lut  = m_lut(pin_in);
        for (int n = 0; n < 16; n++) outs[n] = m_cfg[n][10] ? m_q[n] : lut[n];
        e_irq0 = m_irq[7]  & outs[m_irq[3:0]];
        e_irq1 = m_irq[15] & outs[m_irq[11:8]];
        e_adc  = outs[m_adc[3:0]];
        check(pin_out == outs, "R2 R3 R4 R5 R6 pin_out", 32'(pin_out), 32'(outs));
        check(irq_out == {e_irq1, e_irq0}, "R8 irq_out", 32'(irq_out), 32'({e_irq1, e_irq0}));
        check(adc_start == e_adc, "R9 adc_start", 32'(adc_start), 32'(e_adc));
        check(reg_rdata == m_read(addr), rtag, reg_rdata, m_read(addr));
        // Model commit at the coming rising edge.
        c0 = m_clk[2:0];
        c1 = m_clk[6:4];
        ce0 = (c0 == 0) || ce_src[c0];
        ce1 = (c1 == 0) || ce_src[c1];
        for (int n = 0; n < 16; n++)
            if ((n < 8) ? ce0 : ce1) m_q[n] = lut[n];
        m_dout = outs;
        if (we) begin
            if (addr < 16)       m_cfg[addr] = data[10:0];
            else if (addr == 16) m_clk = data;
            else if (addr == 17) m_irq = data;
            else if (addr == 18) m_adc = data;
            else if (addr == 19) m_din = data;
        end
    endtask

    initial begin
        for (int n = 0; n < 16; n++) m_cfg[n] = '0;
        m_clk = 0; m_irq = 0; m_adc = 0; m_din = 0; m_dout = 0; m_q = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: every register reads zero after reset.
        for (int a = 0; a < 21; a++) step(1'b0, a, 32'd0, "R10 reset read");

        // R4: cross-bank loop through cells 15->0 and 7->8.
        step(1'b1, 15, 32'h720, "R1 write");
        step(1'b1, 7,  32'h720, "R1 write");
        step(1'b1, 0,  32'h300, "R1 write");
        step(1'b1, 8,  32'h300, "R1 write");
        for (int k = 0; k < 40; k++) step(1'b0, k % 21, 32'd0, "R4 cross-bank read");

        // R3: software data bits through operand B.
        step(1'b1, 19, 32'hA5C3, "R1 din write");
        step(1'b1, 3,  32'h140, "R1 write");
        step(1'b1, 11, 32'h540, "R1 write");
        for (int k = 0; k < 20; k++) step(1'b0, 19, 32'd0, "R3 din read");

        // R6: gated banks with distinct codes.
        step(1'b1, 16, 32'h53, "R1 clksel write");
        for (int k = 0; k < 60; k++) step(1'b0, 20, 32'd0, "R6 R7 dout read");

        // R8 / R9: interrupt and conversion-start routing.
        step(1'b1, 17, 32'h8800, "R1 irq write");
        step(1'b1, 18, 32'h7, "R1 adc write");
        for (int k = 0; k < 30; k++) step(1'b0, 17, 32'd0, "R8 irq read");
        step(1'b1, 17, 32'h008F, "R1 irq write");
        for (int k = 0; k < 30; k++) step(1'b0, 18, 32'd0, "R9 adc read");

        // R7: write to the output capture word has no effect.
        step(1'b1, 20, 32'hFFFF_FFFF, "R7 dout write");
        step(1'b0, 20, 32'd0, "R7 dout after write");

        // Random phase, unmapped addresses included.
        for (int k = 0; k < 4000; k++) begin
            int a;
            a = $urandom % 32;
            if ($urandom % 4 == 0) step(1'b1, a, $urandom, "R1 R7 random write");
            else                   step(1'b0, a, 32'd0, "R1 R7 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule